// File: doc/BRIEF.md
# Sequential Signed Multiply/Divide Unit with HI/LO Result Registers

This block performs signed 32x32 multiplication and signed 32/32 division over a number of clock cycles and leaves the outcome in a pair of special result registers, HI and LO. An operation names two source operands and no destination. Multiplication writes the 64-bit product as two halves: the upper half goes to HI and the lower half to LO. Division writes the quotient to LO and the remainder to HI. The pipeline copies a result into a general register by reading the `hi` or `lo` port, which gives the move-from-HI and move-from-LO operations.

Operations enter on a valid/ready handshake. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole time the unit is busy, so the unit applies back-pressure for as long as it is working. A request offered while the unit is busy is not taken and has no effect. The sender need not hold it. The multiplier is a shift-add loop and the divider is a restoring loop. Both work on operand magnitudes and apply the signs at the end.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` is 0, `in_ready` is 1, and `hi` and `lo` are both zero.
- R2: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both 1, and `busy` is 1 from the next cycle. `in_ready` is always the inverse of `busy`.
- R3: After an operation is accepted, `busy` stays high for exactly W+1 cycles (33 at W=32), then falls.
- R4: With `op_sel`=0 (multiply), `{hi,lo}` becomes the two's-complement 64-bit product of the signed operands.
- R5: With `op_sel`=1 (divide) and a nonzero divisor, `lo` becomes the signed quotient rounded toward zero.
- R6: With a nonzero divisor, `hi` becomes the remainder. The remainder has the sign of the dividend and satisfies a = q*b + r.
- R7: Division by zero raises no trap or flag. It sets `lo` to all ones and `hi` to the dividend.
- R8: Dividing the most negative value by -1 gives `lo` equal to the most negative value and `hi` equal to 0.
- R9: While `busy` is high, `hi` and `lo` keep the last completed result.
- R10: A request with `in_valid`=1 while `busy`=1 is ignored. It changes neither the result nor the length of the running operation.
- R11: `hi` and `lo` change only on the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request valid |
| in_ready | output | 1 | Unit can accept a request (inverse of busy) |
| op_sel | input | 1 | 0 = signed multiply, 1 = signed divide |
| src_a | input | W | Multiplicand or dividend |
| src_b | input | W | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| hi | output | W | HI register: upper product half or remainder |
| lo | output | W | LO register: lower product half or quotient |

## Verification
The assertions assume that `rst_n` is asserted from time zero and that `in_valid` and its operands are only ever sampled at a clock edge. They make no assumption about when requests arrive, because a request during `busy` must be harmless. The stimulus changes inputs only on falling clock edges and holds each request for a single accepting edge. It also deliberately raises `in_valid` during `busy` with different operands, so that the ignore rule is exercised rather than assumed.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {OP_MUL = 1'b0, OP_DIV = 1'b1} md_op_e;
endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);
  logic [2*W:0] acc_q;
  logic [W-1:0] mcand_q;
  logic [W:0]   upper_sum;

  always_comb upper_sum = acc_q[2*W:W] + (acc_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk) begin
    if (load) begin
      acc_q   <= {{(W+1){1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (step) begin
      acc_q <= {1'b0, upper_sum, acc_q[W-1:1]};
    end
  end

  assign prod = acc_q[2*W-1:0];
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W:0]   rem_q;
  logic [W-1:0] quo_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   shifted;
  logic [W:0]   trial;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    trial   = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      if (trial[W]) begin
        rem_q <= shifted;
        quo_q <= {quo_q[W-2:0], 1'b0};
      end else begin
        rem_q <= trial;
        quo_q <= {quo_q[W-2:0], 1'b1};
      end
    end
  end

  assign quo = quo_q;
  assign rem = rem_q[W-1:0];
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         op_sel,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  import muldiv_pkg::*;
  localparam int CW = $clog2(W + 1);

  logic           busy_q;
  logic [CW-1:0]  cnt_q;
  md_op_e         op_q;
  logic           neg_q, aneg_q, dz_q;
  logic [W-1:0]   a_q;
  logic [W-1:0]   hi_q, lo_q;
  logic           accept, step, finish;
  logic [W-1:0]   a_mag, b_mag;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;
  logic [2*W-1:0] prod_s;
  logic [W-1:0]   quo_s, rem_s;

  assign in_ready = !busy_q;
  assign accept   = in_valid && !busy_q;
  assign step     = busy_q && (cnt_q != CW'(W));
  assign finish   = busy_q && (cnt_q == CW'(W));
  assign a_mag    = src_a[W-1] ? (~src_a + 1'b1) : src_a;
  assign b_mag    = src_b[W-1] ? (~src_b + 1'b1) : src_b;

  muldiv_mul_core #(.W(W)) u_mul (
    .clk(clk), .load(accept), .step(step),
    .mcand(a_mag), .mplier(b_mag), .prod(prod)
  );

  muldiv_div_core #(.W(W)) u_div (
    .clk(clk), .load(accept), .step(step),
    .dividend(a_mag), .divisor(b_mag), .quo(quo), .rem(rem)
  );

  always_comb begin
    prod_s = neg_q  ? (~prod + 1'b1) : prod;
    quo_s  = neg_q  ? (~quo + 1'b1)  : quo;
    rem_s  = aneg_q ? (~rem + 1'b1)  : rem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_MUL;
      neg_q  <= 1'b0;
      aneg_q <= 1'b0;
      dz_q   <= 1'b0;
      a_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      op_q   <= md_op_e'(op_sel);
      neg_q  <= src_a[W-1] ^ src_b[W-1];
      aneg_q <= src_a[W-1];
      dz_q   <= (src_b == '0);
      a_q    <= src_a;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (finish) begin
      busy_q <= 1'b0;
      if (op_q == OP_MUL) begin
        hi_q <= prod_s[2*W-1:W];
        lo_q <= prod_s[W-1:0];
      end else if (dz_q) begin
        hi_q <= a_q;
        lo_q <= '1;
      end else begin
        hi_q <= rem_s;
        lo_q <= quo_s;
      end
    end
  end

  assign busy = busy_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         busy,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int CW = $clog2(W + 3);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == CW'(W + 1)));

  assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len <= CW'(W)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(hi) && $stable(lo)));

  assert_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(hi) || !$stable(lo)) |-> $fell(busy));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy && (busy_len < CW'(W))) |=> busy);
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .hi(hi), .lo(lo)
);

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  localparam int W = 32;
  localparam int NV = 14;
  // {op_sel, src_a, src_b}; op_sel 0 = multiply, 1 = divide
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 32'd3,          32'd5},
    {1'b0, 32'hFFFFFFF9,   32'd6},
    {1'b0, 32'h80000000,   32'h80000000},
    {1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF},
    {1'b0, 32'h7FFFFFFF,   32'd2},
    {1'b0, 32'h12345678,   32'h9ABCDEF0},
    {1'b1, 32'd100,        32'd7},
    {1'b1, 32'hFFFFFF9C,   32'd7},
    {1'b1, 32'd100,        32'hFFFFFFF9},
    {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9},
    {1'b1, 32'd5,          32'd10},
    {1'b1, 32'h80000000,   32'hFFFFFFFF},
    {1'b1, 32'd7,          32'd0},
    {1'b1, 32'hFFFFFFF9,   32'd0}
  };

  logic clk = 0, rst_n = 0, in_valid = 0, op_sel = 0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic in_ready, busy;
  logic [W-1:0] hi, lo;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  muldiv_hilo #(.W(W)) dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] model(input logic op, input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint q, r;
    logic [63:0] p;
    if (!op) begin
      p = 64'(sa * sb);
      return p;
    end
    if (b == '0) return {a, {W{1'b1}}};
    q = sa / sb;
    r = sa % sb;
    return {r[W-1:0], q[W-1:0]};
  endfunction

  // issue one request, optionally poke in_valid mid-run; return busy cycle count
  task automatic run_op(input logic op, input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit poke, output int cycles);
    @(negedge clk);
    op_sel = op; src_a = a; src_b = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    cycles = 0;
    while (busy && cycles < 100) begin
      cycles++;
      if (poke && cycles == 5) begin
        op_sel = ~op; src_a = 32'h55AA55AA; src_b = 32'd3; in_valid = 1;
      end else in_valid = 0;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  initial begin
    int cyc;
    logic [2*W-1:0] e;
    logic [W-1:0] ph, pl;
    bit hold_ok;
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++; n_run++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    #1;
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 ready", 64'(in_ready), 64'd1);
    check("R1 hilo", {hi, lo}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      e = model(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);
      run_op(VEC[i][2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], 0, cyc);
      if (!VEC[i][2*W]) check("R4 product", {hi, lo}, e);
      else if (VEC[i][W-1:0] == '0) check("R7 div by zero", {hi, lo}, e);
      else if (VEC[i][2*W-1:W] == 32'h80000000 && VEC[i][W-1:0] == '1)
        check("R8 min/-1", {hi, lo}, {32'd0, 32'h80000000});
      else begin
        check("R5 quotient", 64'(lo), 64'(e[W-1:0]));
        check("R6 remainder", 64'(hi), 64'(e[2*W-1:W]));
      end
      check("R3 busy length", 64'(cyc), 64'(W + 1));
    end

    // R2: ready tracks busy, request accepted
    @(negedge clk);
    op_sel = 0; src_a = 32'd9; src_b = 32'd9; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check("R2 busy after accept", 64'(busy), 64'd1);
    check("R2 ready low", 64'(in_ready), 64'd0);
    // R9: old values held while busy
    ph = hi; pl = lo; hold_ok = 1;
    while (busy) begin
      if (hi !== 32'hFFFFFFF9 || lo !== 32'hFFFFFFFF) hold_ok = 0;
      @(negedge clk);
    end
    check("R9 hold while busy", 64'(hold_ok), 64'd1);
    check("R11 updated at end", {hi, lo}, 64'd81);

    // R10: request during busy ignored
    run_op(1, 32'd1000, 32'd33, 1, cyc);
    check("R10 result unchanged", {hi, lo}, {32'd10, 32'd30});
    check("R10 length unchanged", 64'(cyc), 64'(W + 1));
    @(negedge clk);
    check("R10 no extra op", 64'(busy), 64'd0);

    // R1: reset mid-operation restores idle state
    @(negedge clk);
    op_sel = 0; src_a = 32'd7; src_b = 32'd7; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 reset clears", {31'd0, busy, hi}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule